// File: doc/BRIEF.md
# SIMD Element Byte-Order Swap Unit

This unit sits between a 64-bit register-file port and an ALU pipeline port. It reorders bytes so that data stored in one byte order can be handed to the ALU in the other. The word is treated as eight byte lanes. In any one cycle, every element in the word has the same width: eight 8-bit, four 16-bit, two 32-bit or one 64-bit element. When swapping is enabled, the unit reverses the byte order inside each element. When it is disabled, the word passes through untouched.

The swap itself is a one-hot select among four fixed byte permutations: identity, pairs reversed, quads reversed, and the whole word reversed. Each output bit therefore sits behind a shallow AND-OR. Width and swap enable are sampled together with the data, so they may change on every beat and no draining is needed. An output register stage, selected by a parameter and present by default, carries a valid bit and the width code along with the data. The stage follows the data only on valid beats.

Top module: `byte_order_swap`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `out_valid` is 0, `out_data` is all zeros and `out_width` is 0.
- R2: The width code is 2'b00 for 8-bit elements, 2'b01 for 16-bit, 2'b10 for 32-bit and 2'b11 for 64-bit. With `in_swap` = 0, `out_data` equals `in_data` for every width code.
- R3: With width code 2'b00 and `in_swap` = 1, `out_data` equals `in_data`.
- R4: With width code 2'b01 and `in_swap` = 1, output byte i (bits 8i+7:8i) equals input byte i XOR 1.
- R5: With width code 2'b10 and `in_swap` = 1, byte j of each 32-bit half equals byte 3-j of the same half.
- R6: With width code 2'b11 and `in_swap` = 1, output byte i equals input byte 7-i.
- R7: The width code and swap enable may differ on consecutive valid beats. Each beat is transformed by its own setting, with no idle cycles between beats.
- R8: With the output stage present, a beat presented with `in_valid` = 1 appears one clock later with `out_valid` = 1. Its width code appears on `out_width` in the same cycle.
- R9: Passing a word through the unit twice with the same width and swap setting returns the original word.
- R10: A cycle with `in_valid` = 0 drives `out_valid` to 0 and leaves `out_data` and `out_width` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat qualifier |
| in_data | input | 64 | Word from the register-file port |
| in_width | input | 2 | Element width code |
| in_swap | input | 1 | 1 = reverse bytes within each element |
| out_valid | output | 1 | Output beat qualifier |
| out_data | output | 64 | Reordered word toward the ALU |
| out_width | output | 2 | Width code carried with the data |

## Verification
The hardest situation to reach is a change of width and swap setting on every beat with no idle cycle between beats. In that situation a setting that leaks from one beat into the next would go unnoticed by isolated tests. The vector table is streamed back to back, so each beat's setting differs from its neighbour's. The bench checks each result on the cycle after the beat is issued. Random words are then fed through the unit twice in every mode. The final output must match both an element-by-element reference and the original word.

// File: rtl/byte_order_swap.sv
module byte_order_swap #(
  parameter int LANE_W  = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [8*LANE_W-1:0] in_data,
  input  logic [1:0]          in_width,
  input  logic                in_swap,
  output logic                out_valid,
  output logic [8*LANE_W-1:0] out_data,
  output logic [1:0]          out_width
);
  localparam int LANES  = 8;
  localparam int DATA_W = LANES * LANE_W;
  localparam logic [1:0] W8  = 2'b00;
  localparam logic [1:0] W16 = 2'b01;
  localparam logic [1:0] W32 = 2'b10;
  localparam logic [1:0] W64 = 2'b11;

  logic [3:0]        sel;
  logic [DATA_W-1:0] swp;

  assign sel[0] = !in_swap || (in_width == W8);
  assign sel[1] = in_swap && (in_width == W16);
  assign sel[2] = in_swap && (in_width == W32);
  assign sel[3] = in_swap && (in_width == W64);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign swp[i*LANE_W +: LANE_W] =
        ({LANE_W{sel[0]}} & in_data[i*LANE_W +: LANE_W])
      | ({LANE_W{sel[1]}} & in_data[(i ^ 1)*LANE_W +: LANE_W])
      | ({LANE_W{sel[2]}} & in_data[(i ^ 3)*LANE_W +: LANE_W])
      | ({LANE_W{sel[3]}} & in_data[(i ^ 7)*LANE_W +: LANE_W]);
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        out_valid <= 1'b0;
        out_data  <= '0;
        out_width <= W8;
      end else begin
        out_valid <= in_valid;
        if (in_valid) begin
          out_data  <= swp;
          out_width <= in_width;
        end
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_data  = swp;
    assign out_width = in_width;
  end
endmodule

// File: rtl/byte_order_swap_chk.sv
module byte_order_swap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_data,
  input logic [1:0]  in_width,
  input logic        in_swap,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic [1:0]  out_width
);
  p_valid_lat_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (out_valid && out_width == $past(in_width)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(out_width)));

  p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_swap) |=> out_data == $past(in_data));

  p_byte_noop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_width == 2'b00) |=> out_data == $past(in_data));

  p_full_rev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_swap && in_width == 2'b11) |=>
      (out_data[7:0] == $past(in_data[63:56]) && out_data[63:56] == $past(in_data[7:0])));
endmodule

bind byte_order_swap byte_order_swap_chk i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_width(in_width), .in_swap(in_swap), .out_valid(out_valid),
  .out_data(out_data), .out_width(out_width)
);

// File: tb/test_byte_order_swap.sv
module test_byte_order_swap;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;

  localparam logic [63:0] V_IN [NV] = '{
    64'h0706050403020100, 64'h0706050403020100, 64'h0706050403020100,
    64'h0706050403020100, 64'h0706050403020100, 64'h1122334455667788,
    64'h1122334455667788, 64'h1122334455667788, 64'h1122334455667788,
    64'h1122334455667788};
  localparam logic [1:0] V_W [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd3, 2'd1, 2'd2, 2'd3, 2'd0, 2'd2};
  localparam logic V_S [NV] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0};
  localparam logic [63:0] V_EXP [NV] = '{
    64'h0706050403020100, 64'h0607040502030001, 64'h0405060700010203,
    64'h0001020304050607, 64'h0706050403020100, 64'h2211443366558877,
    64'h4433221188776655, 64'h8877665544332211, 64'h1122334455667788,
    64'h1122334455667788};
  localparam string V_REQ [NV] = '{"R3", "R4", "R5", "R6", "R2", "R4", "R5", "R6", "R3", "R2"};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic [1:0] in_width = '0;
  logic in_swap = 1'b0;
  logic out_valid;
  logic [63:0] out_data;
  logic [1:0] out_width;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_order_swap i_byte_order_swap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_width(in_width), .in_swap(in_swap), .out_valid(out_valid),
    .out_data(out_data), .out_width(out_width));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_swap(input logic [63:0] d, input logic [1:0] w, input logic s);
    logic [63:0] r;
    int k;
    r = d;
    k = 1 << w;
    if (s)
      for (int e = 0; e < 8 / k; e++)
        for (int p = 0; p < k; p++)
          r[(e*k + p)*8 +: 8] = d[(e*k + k - 1 - p)*8 +: 8];
    return r;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 data", out_data, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 width", {62'd0, out_width}, 64'd0);

    // R7: table streamed back to back, setting changes every beat
    for (int v = 0; v <= NV; v++) begin
      if (v > 0) begin
        chk({V_REQ[v-1], " R7"}, out_data, V_EXP[v-1]);
        chk("R8 valid", {63'd0, out_valid}, 64'd1);
        chk("R8 width", {62'd0, out_width}, {62'd0, V_W[v-1]});
      end
      if (v < NV) begin
        in_valid = 1'b1; in_data = V_IN[v]; in_width = V_W[v]; in_swap = V_S[v];
      end else in_valid = 1'b0;
      @(negedge clk);
    end

    // R10: idle beat holds data and width
    in_valid = 1'b1; in_data = 64'hDEADBEEF01234567; in_width = 2'd1; in_swap = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; in_data = 64'hFFFFFFFFFFFFFFFF; in_width = 2'd3;
    @(negedge clk);
    chk("R10 valid", {63'd0, out_valid}, 64'd0);
    chk("R10 data", out_data, 64'hADDEEFBE23016745);
    chk("R10 width", {62'd0, out_width}, 64'd1);

    // R9: twice through in every mode with random data
    for (int n = 0; n < 40; n++) begin
      logic [63:0] d, once;
      logic [1:0] w;
      logic s;
      d = {$urandom, $urandom};
      w = 2'(n % 4);
      s = 1'((n / 4) % 2);
      in_valid = 1'b1; in_data = d; in_width = w; in_swap = s;
      @(negedge clk);
      once = out_data;
      chk("R9 first pass", once, ref_swap(d, w, s));
      in_data = once;
      @(negedge clk);
      chk("R9 second pass", out_data, d);
    end
    in_valid = 1'b0;

    // R1: reset mid-stream clears the output
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reassert", {63'd0, out_valid}, 64'd0);
    chk("R1 reassert data", out_data, 64'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule